// File: doc/BRIEF.md
# Soft-Ramp Zero-Cross Volume Controller

This block is a single-channel digital attenuator for one lane of a multichannel audio path. It takes signed 24-bit samples, each marked by a one-cycle strobe. It also takes a 7-bit attenuation request in 1 dB units, a mute request and a 2-bit change-mode select. A multichannel design places one copy per channel, so each channel does its own zero-crossing detection and timeout.

Inside, the applied level is an index in eighth-dB units. That index moves toward the requested level in one of four ways: in one jump, in one jump held back until the waveform crosses zero, one eighth-dB step per frame, or one eighth-dB step per zero crossing. In the two zero-crossing modes a per-channel timeout forces the change when no crossing arrives. A small octave table turns the index into a linear multiplier, and the scaled sample is registered on each strobe. A flag reports when the applied level equals the requested one.

Top module: `soft_volume`

## Requirements
- R1: After reset, `sampleOut` is 0, the applied index is 0 (0 dB), the timeout count is 0 and the stored previous sign is positive. With `attenCode`=0 and `muteReq`=0, `levelReached` is therefore 1.
- R2: Let the applied index be `g`, in 1/8 dB units. With q=g/48 and r=g%48, the output is floor(sample*M[r] / 2^(16+q)). M[0]=65536 and M[r]=floor(M[r-1]*64600/65536). The index is never above 1024.
- R3: State and output change only on a cycle where `sampleValid` is 1. The registered output then uses the index after that strobe's update. Between strobes, `sampleOut` holds.
- R4: With `chgMode`=0 (immediate), the index jumps to the target on the strobe.
- R5: With `chgMode`=2 (soft ramp), each strobe moves the index one unit (1/8 dB) toward the target, so one dB takes 8 frames. A new target takes effect on the next strobe, from wherever the index stands.
- R6: A strobe counts as a zero crossing when the sample is exactly 0, or when its sign bit (bit 23) differs from the sign bit of the previous strobed sample.
- R7: With `chgMode`=1 (zero-cross), a pending change jumps the index to the target on the first strobe that is a zero crossing.
- R8: In modes 1 and 3, a 10-bit count runs over strobes that have a change pending but no crossing. The change is forced on the 1024th such strobe. The count clears after every applied change and whenever nothing is pending.
- R9: With `chgMode`=3 (soft ramp on zero crossings), each crossing or forced timeout moves the index one unit toward the target. Each step waits again.
- R10: When `muteReq`=1, the target is index 1024 and is reached under the same mode rules. At index 1024 the output is 0. Clearing the mute returns the index toward 8*`attenCode`.
- R11: `levelReached` is 1 exactly when the applied index equals the target, which is 1024 when muted and otherwise 8*`attenCode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe for each new sample (once per frame) |
| sampleIn | input | 24 | Signed input sample |
| attenCode | input | 7 | Requested attenuation, 1 dB per code, 0 = 0 dB |
| muteReq | input | 1 | Drive the level to full attenuation |
| chgMode | input | 2 | 0 immediate, 1 zero-cross, 2 soft ramp, 3 ramp on zero crossings |
| sampleOut | output | 24 | Scaled sample, registered on each strobe |
| levelReached | output | 1 | Applied level equals the requested level |

## Verification
Full-scale positive and negative samples at 0 dB show that the unity gain of the multiplier path is exact. A 6 dB request shows the octave shift on its own. Runs of same-sign samples are set against samples with alternating signs and exact zeros. The first hold the level back until the timeout boundary, and the bench checks that they do not change it one strobe early. The second show that the crossing detector, not the timeout, releases each change. Ramps are checked step by step against a count of frames. Mute, unmute and retargeting during a ramp are then mixed at random with random samples and modes, all against a bench model of the index, the timeout count and the gain law.

// File: rtl/soft_volume_pkg.sv
package soft_volume_pkg;

  localparam int SV_DATA_W     = 24;
  localparam int SV_ATTEN_W    = 7;
  localparam int SV_TMO_W      = 10;
  localparam int SV_STEP_DIV   = 8;                          // index units per dB
  localparam int SV_STEP_SH    = $clog2(SV_STEP_DIV);
  localparam int SV_MUTE_IDX   = (1 << SV_ATTEN_W) * SV_STEP_DIV;
  localparam int SV_IDX_W      = $clog2(SV_MUTE_IDX + 1);
  localparam int SV_OCT_STEPS  = 6 * SV_STEP_DIV;            // one halving of gain
  localparam int SV_FRAC_W     = $clog2(SV_OCT_STEPS);
  localparam int SV_FRAC_SH    = 16;
  localparam int SV_MANT_W     = SV_FRAC_SH + 1;
  localparam longint SV_STEP_RATIO = 64600;                  // 2^16 * 10^(-1/160)

  typedef enum logic [1:0] {
    CHG_IMMEDIATE  = 2'd0,
    CHG_ZEROX      = 2'd1,
    CHG_RAMP       = 2'd2,
    CHG_RAMP_ZEROX = 2'd3
  } chgMode_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic                load;
    logic [SV_IDX_W-1:0] gainIdx;
  } volStrobe_t;

  // Mantissa for fractional octave position r, by repeated eighth-dB scaling
  function automatic logic [SV_MANT_W-1:0] mantFor(input int r);
    longint m;
    m = longint'(1) << SV_FRAC_SH;
    for (int i = 0; i < r; i++) m = (m * SV_STEP_RATIO) >>> SV_FRAC_SH;
    return m[SV_MANT_W-1:0];
  endfunction

endpackage

// File: rtl/soft_volume_ctrl.sv
module soft_volume_ctrl
  import soft_volume_pkg::*;
#(
  parameter int ATTEN_W = SV_ATTEN_W,
  parameter int TMO_W   = SV_TMO_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic                sampleSign,
  input  logic                sampleZero,
  input  logic [ATTEN_W-1:0]  attenCode,
  input  logic                muteReq,
  input  logic [1:0]          chgMode,
  output volStrobe_t          strobes,
  output logic [SV_IDX_W-1:0] curIdxOut,
  output logic                levelReached
);

  logic [SV_IDX_W-1:0] curIdx, nextIdx, targetIdx, stepIdx;
  logic [TMO_W-1:0]    tmoCnt, nextTmo;
  logic                prevSign, zeroX, pending, tmoHit, applyNow;
  chgMode_t            modeSel;

  assign modeSel   = chgMode_t'(chgMode);
  assign targetIdx = muteReq ? SV_IDX_W'(SV_MUTE_IDX)
                             : (SV_IDX_W'(attenCode) << SV_STEP_SH);

  always_comb begin
    zeroX    = sampleZero || (sampleSign != prevSign);
    pending  = (curIdx != targetIdx);
    tmoHit   = &tmoCnt;
    applyNow = zeroX || tmoHit;
    stepIdx  = (curIdx < targetIdx) ? curIdx + 1'b1 : curIdx - 1'b1;
    nextIdx  = curIdx;
    nextTmo  = '0;
    if (pending) begin
      case (modeSel)
        CHG_IMMEDIATE: nextIdx = targetIdx;
        CHG_RAMP:      nextIdx = stepIdx;
        CHG_ZEROX: begin
          if (applyNow) nextIdx = targetIdx;
          else          nextTmo = tmoCnt + 1'b1;
        end
        CHG_RAMP_ZEROX: begin
          if (applyNow) nextIdx = stepIdx;
          else          nextTmo = tmoCnt + 1'b1;
        end
        default: nextIdx = curIdx;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx   <= '0;
      tmoCnt   <= '0;
      prevSign <= 1'b0;
    end else if (sampleValid) begin
      curIdx   <= nextIdx;
      tmoCnt   <= nextTmo;
      prevSign <= sampleSign;
    end
  end

  assign strobes.load    = sampleValid;
  assign strobes.gainIdx = nextIdx;
  assign curIdxOut       = curIdx;
  assign levelReached    = (curIdx == targetIdx);

endmodule

// File: rtl/soft_volume_dp.sv
module soft_volume_dp
  import soft_volume_pkg::*;
#(
  parameter int DATA_W = SV_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  volStrobe_t        strobes,
  output logic [DATA_W-1:0] sampleOut
);

  localparam int PROD_W = DATA_W + SV_MANT_W + 1;

  logic [SV_MANT_W-1:0] mantTab [SV_OCT_STEPS];

  for (genvar r = 0; r < SV_OCT_STEPS; r++) begin : g_mant
    localparam logic [SV_MANT_W-1:0] MANT_R = mantFor(r);
    assign mantTab[r] = MANT_R;
  end

  int                       octInt, fracInt;
  logic [SV_FRAC_W-1:0]     fracSel;
  logic [SV_MANT_W-1:0]     mantSel;
  logic signed [PROD_W-1:0] sampleExt, mantExt, prodVal, shifted;
  logic [DATA_W-1:0]        scaled;

  always_comb begin
    octInt    = int'(strobes.gainIdx) / SV_OCT_STEPS;
    fracInt   = int'(strobes.gainIdx) - octInt * SV_OCT_STEPS;
    fracSel   = fracInt[SV_FRAC_W-1:0];
    mantSel   = mantTab[fracSel];
    sampleExt = {{(PROD_W-DATA_W){sampleIn[DATA_W-1]}}, sampleIn};
    mantExt   = {{(PROD_W-SV_MANT_W){1'b0}}, mantSel};
    prodVal   = sampleExt * mantExt;
    shifted   = prodVal >>> (SV_FRAC_SH + octInt);
    scaled    = (strobes.gainIdx == SV_IDX_W'(SV_MUTE_IDX)) ? '0 : shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             sampleOut <= '0;
    else if (strobes.load) sampleOut <= scaled;
  end

endmodule

// File: rtl/soft_volume.sv
module soft_volume
  import soft_volume_pkg::*;
#(
  parameter int DATA_W  = SV_DATA_W,
  parameter int ATTEN_W = SV_ATTEN_W,
  parameter int TMO_W   = SV_TMO_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [DATA_W-1:0]  sampleIn,
  input  logic [ATTEN_W-1:0] attenCode,
  input  logic               muteReq,
  input  logic [1:0]         chgMode,
  output logic [DATA_W-1:0]  sampleOut,
  output logic               levelReached
);

  volStrobe_t          strobes;
  logic [SV_IDX_W-1:0] gainIdx;

  soft_volume_ctrl #(.ATTEN_W(ATTEN_W), .TMO_W(TMO_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .sampleSign   (sampleIn[DATA_W-1]),
    .sampleZero   (sampleIn == '0),
    .attenCode    (attenCode),
    .muteReq      (muteReq),
    .chgMode      (chgMode),
    .strobes      (strobes),
    .curIdxOut    (gainIdx),
    .levelReached (levelReached)
  );

  soft_volume_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleIn  (sampleIn),
    .strobes   (strobes),
    .sampleOut (sampleOut)
  );

endmodule

// File: rtl/soft_volume_chk.sv
module soft_volume_chk
  import soft_volume_pkg::*;
#(
  parameter int DATA_W  = SV_DATA_W,
  parameter int ATTEN_W = SV_ATTEN_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [ATTEN_W-1:0]  attenCode,
  input logic                muteReq,
  input logic [1:0]          chgMode,
  input logic [SV_IDX_W-1:0] gainIdx,
  input logic [DATA_W-1:0]   sampleOut
);

  logic [SV_IDX_W-1:0] tgtIdx;
  assign tgtIdx = muteReq ? SV_IDX_W'(SV_MUTE_IDX) : SV_IDX_W'(attenCode) * SV_IDX_W'(SV_STEP_DIV);

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(sampleOut));

  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(gainIdx));

  p_immediate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && chgMode == 2'd0) |=> gainIdx == $past(tgtIdx));

  p_ramp_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && chgMode == 2'd2 && gainIdx != tgtIdx)
      |=> (gainIdx == $past(gainIdx) + 1'b1) || (gainIdx == $past(gainIdx) - 1'b1));

  p_zerox_jump_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && chgMode == 2'd1)
      |=> (gainIdx == $past(gainIdx)) || (gainIdx == $past(tgtIdx)));

  p_mute_silent_r10: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> (gainIdx != SV_IDX_W'(SV_MUTE_IDX)) || (sampleOut == '0));

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    gainIdx <= SV_IDX_W'(SV_MUTE_IDX));

endmodule

bind soft_volume soft_volume_chk #(.DATA_W(DATA_W), .ATTEN_W(ATTEN_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .attenCode   (attenCode),
  .muteReq     (muteReq),
  .chgMode     (chgMode),
  .gainIdx     (gainIdx),
  .sampleOut   (sampleOut)
);

// File: tb/tb_soft_volume.sv
module tb_soft_volume;

  logic               clk = 1'b0;
  logic               rstN;
  logic               sampleValid;
  logic signed [23:0] sampleIn;
  logic [6:0]         attenCode;
  logic               muteReq;
  logic [1:0]         chgMode;
  logic [23:0]        sampleOut;
  logic               levelReached;

  int     nChecks = 0;
  int     nFails  = 0;
  bit     done    = 0;
  longint mant [48];
  int     mIdx, mTmo;
  bit     mPrev;
  logic signed [23:0] expOut;

  always #4 clk = ~clk;

  soft_volume dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .attenCode(attenCode), .muteReq(muteReq), .chgMode(chgMode),
    .sampleOut(sampleOut), .levelReached(levelReached)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  function automatic int tgtOf();
    return muteReq ? 1024 : int'(attenCode) * 8;
  endfunction

  // R2 gain law
  function automatic logic signed [23:0] expScale(input logic signed [23:0] s, input int idx);
    longint p;
    int q, r;
    if (idx == 1024) return 24'sd0;
    q = idx / 48;
    r = idx % 48;
    p = longint'(s) * mant[r];
    p = p >>> (16 + q);
    return p[23:0];
  endfunction

  // Model of one strobe (R4..R10)
  task automatic modelStep(input logic signed [23:0] s);
    int  tgt, stepTo;
    bit  zc;
    tgt = tgtOf();
    zc  = (s == 0) || (s[23] != mPrev);
    mPrev = s[23];
    stepTo = (mIdx < tgt) ? mIdx + 1 : mIdx - 1;
    if (mIdx == tgt) mTmo = 0;
    else begin
      case (chgMode)
        2'd0: begin mIdx = tgt; mTmo = 0; end
        2'd2: begin mIdx = stepTo; mTmo = 0; end
        2'd1: if (zc || mTmo == 1023) begin mIdx = tgt; mTmo = 0; end else mTmo++;
        default: if (zc || mTmo == 1023) begin mIdx = stepTo; mTmo = 0; end else mTmo++;
      endcase
    end
    expOut = expScale(s, mIdx);
  endtask

  task automatic doSample(input logic signed [23:0] s, input string tag);
    @(negedge clk);
    sampleIn    = s;
    sampleValid = 1'b1;
    modelStep(s);
    @(negedge clk);
    sampleValid = 1'b0;
    chk(sampleOut == expOut, {tag, " out"}, longint'($signed(sampleOut)), longint'(expOut));
    chk(levelReached == (mIdx == tgtOf()), "R11 levelReached",
        longint'(levelReached), longint'(mIdx == tgtOf()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [23:0] held;
    void'($urandom(32'd7391));
    mant[0] = 65536;
    for (int r = 1; r < 48; r++) mant[r] = (mant[r-1] * 64600) >>> 16;
    mIdx = 0; mTmo = 0; mPrev = 0;

    rstN = 0; sampleValid = 0; sampleIn = 0; attenCode = 0; muteReq = 0; chgMode = 2'd2;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(sampleOut == 0, "R1 reset output", longint'(sampleOut), 0);
    chk(levelReached == 1, "R1 reset level", longint'(levelReached), 1);

    // R2 unity gain at full scale
    chgMode = 2'd0;
    doSample(-24'sd8388608, "R2 full negative");
    chk($signed(sampleOut) == -24'sd8388608, "R2 unity neg", longint'($signed(sampleOut)), -8388608);
    doSample(24'sd8388607, "R2 full positive");
    chk(sampleOut == 24'd8388607, "R2 unity pos", longint'(sampleOut), 8388607);

    // R4 immediate 6 dB -> exact halving
    attenCode = 7'd6;
    doSample(24'sd4000, "R4 immediate");
    chk(sampleOut == 24'd2000, "R4 half gain", longint'(sampleOut), 2000);

    // R3 hold between strobes
    held = sampleOut;
    repeat (3) @(negedge clk);
    chk(sampleOut == held, "R3 hold", longint'(sampleOut), longint'(held));

    // R10 mute and unmute
    muteReq = 1;
    doSample(24'sd12345, "R10 mute");
    chk(sampleOut == 0, "R10 muted zero", longint'(sampleOut), 0);
    muteReq = 0; attenCode = 0;
    doSample(24'sd5, "R10 unmute");
    chk(sampleOut == 24'd5, "R10 unmuted", longint'(sampleOut), 5);

    // R5 soft ramp 1 dB over 8 frames
    chgMode = 2'd2; attenCode = 7'd1;
    for (int i = 0; i < 7; i++) begin
      doSample(24'sd1000000, "R5 ramp");
      chk(levelReached == 0, "R5 not yet reached", longint'(levelReached), 0);
    end
    doSample(24'sd1000000, "R5 ramp");
    chk(levelReached == 1, "R5 reached after 8", longint'(levelReached), 1);

    // R7 zero-cross jump on sign change
    chgMode = 2'd1; attenCode = 7'd3;
    doSample(24'sd100, "R7 wait");
    doSample(24'sd200, "R7 wait");
    chk(levelReached == 0, "R7 held before crossing", longint'(levelReached), 0);
    doSample(-24'sd50, "R7 crossing");
    chk(levelReached == 1, "R7 applied at crossing", longint'(levelReached), 1);

    // R6 exact zero counts as crossing
    attenCode = 7'd5;
    doSample(-24'sd300, "R6 wait");
    doSample(24'sd0, "R6 zero sample");
    chk(levelReached == 1, "R6 zero crossing", longint'(levelReached), 1);

    // R8 timeout in zero-cross mode
    attenCode = 7'd10;
    doSample(24'sd1000, "R8 first");  // sign change from zero? zero has sign 0: no crossing
    for (int i = 1; i < 1023; i++) doSample(24'sd1000, "R8 waiting");
    chk(levelReached == 0, "R8 not before 1024th", longint'(levelReached), 0);
    doSample(24'sd1000, "R8 forced");
    chk(levelReached == 1, "R8 forced at 1024th", longint'(levelReached), 1);

    // R9 ramp on zero crossings: alternating signs step every frame
    chgMode = 2'd3; attenCode = 7'd11;
    for (int i = 0; i < 8; i++) doSample((i % 2 == 0) ? -24'sd7000 : 24'sd7000, "R9 step per crossing");
    chk(levelReached == 1, "R9 reached after 8 crossings", longint'(levelReached), 1);
    attenCode = 7'd12;
    for (int i = 0; i < 1024; i++) doSample(24'sd7000, "R9 timeout step");
    chk(levelReached == 0, "R9 one step only", longint'(levelReached), 0);
    chgMode = 2'd0;
    doSample(24'sd7000, "R4 settle");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic signed [23:0] s;
      if (n % 40 == 0) begin
        chgMode   = 2'($urandom_range(0, 3));
        attenCode = 7'($urandom_range(0, 127));
        muteReq   = ($urandom_range(0, 7) == 0);
      end
      case ($urandom_range(0, 9))
        0:       s = 24'sd0;
        1, 2, 3: s = 24'($urandom_range(1, 8388607));
        default: s = 24'($urandom);
      endcase
      doSample(s, "R2 R5 R9 random");
      if ($urandom_range(0, 15) == 0) begin
        held = sampleOut;
        @(negedge clk);
        chk(sampleOut == held, "R3 random hold", longint'(sampleOut), longint'(held));
      end
    end

    finishRun();
  end

endmodule